// File: doc/BRIEF.md
# Read Capture Per-Bit Deskew Calibrator

This block calibrates the read capture path of one byte lane of a double-data-rate memory interface during power-up initialization. While the memory returns a fixed training pattern from its multipurpose register, the block steps the read strobe delay through every setting. At each setting it compares the captured data, already split into a rising-edge half and a falling-edge half, with the expected pattern. It keeps a pass or fail result for each data bit separately.

When the sweep ends, the block finds each bit's passing window and picks one strobe delay for the whole lane. It then works out a data delay for each bit that centres that bit's window on the chosen strobe. The delay cells, the read command generation and the loading of the training pattern are handled outside the block. The block only drives tap values and consumes captured samples.

The controller is a state machine with six states. IDLE waits for a start. COLLECT gathers samples at the current strobe tap. STEP closes one tap and updates each bit's window tracker. CHOOSE registers the strobe tap and the error flag. APPLY registers the per-bit taps. DONE holds the results. The transitions are:
- IDLE→COLLECT on start.
- COLLECT→STEP on the last valid sample of a tap.
- STEP→COLLECT while taps remain.
- STEP→CHOOSE after the top tap.
- CHOOSE→APPLY and APPLY→DONE unconditionally.
- DONE→COLLECT on a new start.

Top module: `rl_deskew_cal`

## Requirements
- R1: After reset, cal_done and cal_err are 0, dqs_tap is 0 and every per-bit tap is 0.
- R2: A start seen in IDLE or DONE begins a sweep at strobe tap 0 and clears cal_done and cal_err. Every per-bit tap reads 0 until the sweep completes. A start during a calibration is ignored.
- R3: Each strobe tap collects SAMPLES captured words. Cycles with cap_valid low are ignored.
- R4: A bit passes a tap only if, on every sample of that tap, its rising half equals exp_rise and its falling half equals exp_fall.
- R5: The strobe tap rises by exactly one after each tap is closed, covering 0 to 2^TAP_W-1 in order. After the top tap, the block goes to result selection.
- R6: A bit's window is its longest contiguous run of passing taps, held as a first tap and a last tap. Between equal runs, the lower one is kept.
- R7: When the windows of all bits that have one share at least one tap, dqs_tap becomes floor((largest first + smallest last)/2).
- R8: When those windows share no tap, dqs_tap becomes floor((smallest first + largest last)/2).
- R9: Bit i's tap, at bit_taps[i*BTAP_W +: BTAP_W], equals dqs_tap minus floor((first+last)/2) of its window, clamped to the range 0 to 2^BTAP_W-1.
- R10: A bit with no passing tap sets cal_err. That bit's tap is 0 and the bit is left out of strobe selection; if no bit passes, dqs_tap is 0. cal_err stays set until the next start.
- R11: When calibration completes, cal_done rises. cal_done, cal_err, dqs_tap and bit_taps then hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_start | input | 1 | Begin a calibration |
| cal_done | output | 1 | Calibration finished, results valid |
| cal_err | output | 1 | At least one bit never passed |
| dqs_tap | output | TAP_W | Read strobe delay tap |
| bit_taps | output | NBITS*BTAP_W | Per-bit data delay taps, packed |
| cap_valid | input | 1 | Captured word valid this cycle |
| cap_rise | input | NBITS | Captured rising-edge half |
| cap_fall | input | NBITS | Captured falling-edge half |
| exp_rise | input | NBITS | Expected rising-edge pattern |
| exp_fall | input | NBITS | Expected falling-edge pattern |

## Verification
Some properties are checked by assertions on every cycle:
- The sweep starts at tap 0 and advances one tap per closed step.
- The sweep leaves for selection only after the top tap.
- Per-bit taps stay at zero during the sweep.
- The error flag can rise only out of the selection state.
- The results stay frozen while done is held.

Other properties need the bench's scenarios. These are the choice of window under gaps, islands and ties; the intersection versus union midpoint; clamping at zero; the rejection of a single bad falling-half sample; and the handling of dead bits. Each scenario builds a pass map at the ports and compares the registered results against a model computed from the requirements.

// File: rtl/rl_cal_pkg.sv
package rl_cal_pkg;
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_COLLECT = 3'd1,
        S_STEP    = 3'd2,
        S_CHOOSE  = 3'd3,
        S_APPLY   = 3'd4,
        S_DONE    = 3'd5
    } cal_state_t;
endpackage

// File: rtl/rl_window_tracker.sv
// Tracks the longest contiguous passing run of one bit across the sweep.
module rl_window_tracker #(
    parameter int TAP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             pass,
    input  logic [TAP_W-1:0] tap,
    output logic             found,
    output logic [TAP_W-1:0] first,
    output logic [TAP_W-1:0] last
);
    localparam int LEN_W = TAP_W + 1;

    logic             in_run;
    logic [TAP_W-1:0] run_start;
    logic [LEN_W-1:0] run_len;
    logic [LEN_W-1:0] best_len;
    logic [LEN_W-1:0] len_next;
    logic [TAP_W-1:0] start_next;

    always_comb begin
        len_next   = in_run ? run_len + LEN_W'(1) : LEN_W'(1);
        start_next = in_run ? run_start : tap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_run    <= 1'b0;
            run_start <= '0;
            run_len   <= '0;
            best_len  <= '0;
            first     <= '0;
            last      <= '0;
        end else if (clear) begin
            in_run    <= 1'b0;
            run_start <= '0;
            run_len   <= '0;
            best_len  <= '0;
            first     <= '0;
            last      <= '0;
        end else if (step) begin
            if (pass) begin
                in_run    <= 1'b1;
                run_len   <= len_next;
                run_start <= start_next;
                // strictly longer only: the lower of equal runs is kept
                if (len_next > best_len) begin
                    best_len <= len_next;
                    first    <= start_next;
                    last     <= tap;
                end
            end else begin
                in_run  <= 1'b0;
                run_len <= '0;
            end
        end
    end

    assign found = (best_len != '0);
endmodule

// File: rtl/rl_strobe_select.sv
// Chooses the lane strobe tap from all bit windows.
module rl_strobe_select #(
    parameter int NBITS = 8,
    parameter int TAP_W = 5
) (
    input  logic [NBITS-1:0]       found,
    input  logic [NBITS*TAP_W-1:0] first_flat,
    input  logic [NBITS*TAP_W-1:0] last_flat,
    output logic [TAP_W-1:0]       strobe
);
    localparam logic [TAP_W-1:0] TAP_MAX = '1;

    logic [TAP_W-1:0] in_lo, in_hi, un_lo, un_hi;
    logic [TAP_W:0]   sum;

    always_comb begin
        in_lo = '0;
        in_hi = TAP_MAX;
        un_lo = TAP_MAX;
        un_hi = '0;
        for (int i = 0; i < NBITS; i++) begin
            if (found[i]) begin
                if (first_flat[i*TAP_W +: TAP_W] > in_lo) in_lo = first_flat[i*TAP_W +: TAP_W];
                if (last_flat[i*TAP_W +: TAP_W]  < in_hi) in_hi = last_flat[i*TAP_W +: TAP_W];
                if (first_flat[i*TAP_W +: TAP_W] < un_lo) un_lo = first_flat[i*TAP_W +: TAP_W];
                if (last_flat[i*TAP_W +: TAP_W]  > un_hi) un_hi = last_flat[i*TAP_W +: TAP_W];
            end
        end
        if (in_lo <= in_hi) sum = {1'b0, in_lo} + {1'b0, in_hi};
        else                sum = {1'b0, un_lo} + {1'b0, un_hi};
        strobe = (found == '0) ? '0 : sum[TAP_W:1];
    end
endmodule

// File: rtl/rl_bit_delay.sv
// Per-bit data delay: strobe minus window centre, clamped to the delay line.
module rl_bit_delay #(
    parameter int TAP_W  = 5,
    parameter int BTAP_W = 4
) (
    input  logic              found,
    input  logic [TAP_W-1:0]  strobe,
    input  logic [TAP_W-1:0]  first,
    input  logic [TAP_W-1:0]  last,
    output logic [BTAP_W-1:0] tap
);
    localparam int DW = TAP_W + 2;
    localparam logic signed [DW-1:0] BMAX = DW'((1 << BTAP_W) - 1);

    logic [TAP_W:0]         wsum;
    logic [TAP_W-1:0]       centre;
    logic signed [DW-1:0]   diff;

    always_comb begin
        wsum   = {1'b0, first} + {1'b0, last};
        centre = wsum[TAP_W:1];
        diff   = $signed({2'b00, strobe}) - $signed({2'b00, centre});
        if (!found || diff < 0) tap = '0;
        else if (diff > BMAX)   tap = '1;
        else                    tap = diff[BTAP_W-1:0];
    end
endmodule

// File: rtl/rl_deskew_cal.sv
module rl_deskew_cal
    import rl_cal_pkg::*;
#(
    parameter int NBITS   = 8,
    parameter int TAP_W   = 5,
    parameter int BTAP_W  = 4,
    parameter int SAMPLES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cal_start,
    output logic                    cal_done,
    output logic                    cal_err,
    output logic [TAP_W-1:0]        dqs_tap,
    output logic [NBITS*BTAP_W-1:0] bit_taps,
    input  logic                    cap_valid,
    input  logic [NBITS-1:0]        cap_rise,
    input  logic [NBITS-1:0]        cap_fall,
    input  logic [NBITS-1:0]        exp_rise,
    input  logic [NBITS-1:0]        exp_fall
);
    localparam int               CNT_W    = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLES - 1);
    localparam logic [TAP_W-1:0] TAP_MAX  = '1;

    cal_state_t state_q, state_d;

    logic [TAP_W-1:0]        tap_q;
    logic [CNT_W-1:0]        cnt_q;
    logic [NBITS-1:0]        pass_q;
    logic                    err_q;
    logic [NBITS*BTAP_W-1:0] btap_q;

    logic                    launch;
    logic                    last_sample;
    logic [NBITS-1:0]        mism;
    logic [NBITS-1:0]        found;
    logic [NBITS*TAP_W-1:0]  first_flat, last_flat;
    logic [TAP_W-1:0]        strobe_sel;
    logic [NBITS*BTAP_W-1:0] btap_calc;

    assign launch      = cal_start && (state_q == S_IDLE || state_q == S_DONE);
    assign last_sample = cap_valid && (cnt_q == CNT_LAST);
    assign mism        = (cap_rise ^ exp_rise) | (cap_fall ^ exp_fall);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (cal_start) state_d = S_COLLECT;
            S_COLLECT: if (last_sample) state_d = S_STEP;
            S_STEP:    state_d = (tap_q == TAP_MAX) ? S_CHOOSE : S_COLLECT;
            S_CHOOSE:  state_d = S_APPLY;
            S_APPLY:   state_d = S_DONE;
            S_DONE:    if (cal_start) state_d = S_COLLECT;
            default:   state_d = S_IDLE;
        endcase
    end

    // output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_q  <= '0;
            cnt_q  <= '0;
            pass_q <= '1;
            err_q  <= 1'b0;
            btap_q <= '0;
        end else if (launch) begin
            tap_q  <= '0;
            cnt_q  <= '0;
            pass_q <= '1;
            err_q  <= 1'b0;
            btap_q <= '0;
        end else begin
            unique case (state_q)
                S_COLLECT: if (cap_valid) begin
                    pass_q <= pass_q & ~mism;
                    cnt_q  <= last_sample ? '0 : cnt_q + CNT_W'(1);
                end
                S_STEP: if (tap_q != TAP_MAX) begin
                    tap_q  <= tap_q + TAP_W'(1);
                    pass_q <= '1;
                end
                S_CHOOSE: begin
                    tap_q <= strobe_sel;
                    err_q <= ~&found;
                end
                S_APPLY: btap_q <= btap_calc;
                default: ;
            endcase
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NBITS; gi++) begin : g_bit
            rl_window_tracker #(.TAP_W(TAP_W)) u_trk (
                .clk   (clk),
                .rst_n (rst_n),
                .clear (launch),
                .step  (state_q == S_STEP),
                .pass  (pass_q[gi]),
                .tap   (tap_q),
                .found (found[gi]),
                .first (first_flat[gi*TAP_W +: TAP_W]),
                .last  (last_flat[gi*TAP_W +: TAP_W])
            );
            rl_bit_delay #(.TAP_W(TAP_W), .BTAP_W(BTAP_W)) u_dly (
                .found  (found[gi]),
                .strobe (tap_q),
                .first  (first_flat[gi*TAP_W +: TAP_W]),
                .last   (last_flat[gi*TAP_W +: TAP_W]),
                .tap    (btap_calc[gi*BTAP_W +: BTAP_W])
            );
        end
    endgenerate

    rl_strobe_select #(.NBITS(NBITS), .TAP_W(TAP_W)) u_sel (
        .found      (found),
        .first_flat (first_flat),
        .last_flat  (last_flat),
        .strobe     (strobe_sel)
    );

    assign cal_done = (state_q == S_DONE);
    assign cal_err  = err_q;
    assign dqs_tap  = tap_q;
    assign bit_taps = btap_q;
endmodule

// File: rtl/rl_deskew_cal_chk.sv
module rl_deskew_cal_chk
    import rl_cal_pkg::*;
#(
    parameter int NBITS  = 8,
    parameter int TAP_W  = 5,
    parameter int BTAP_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cal_start,
    input logic                    cal_done,
    input logic                    cal_err,
    input logic [TAP_W-1:0]        dqs_tap,
    input logic [NBITS*BTAP_W-1:0] bit_taps,
    input cal_state_t              state
);
    localparam logic [TAP_W-1:0] TAP_MAX = '1;

    assert_sweep_from_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE || state == S_DONE) && cal_start |=> state == S_COLLECT && dqs_tap == '0);

    assert_taps_zero_in_sweep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COLLECT || state == S_STEP) |-> bit_taps == '0 && !cal_done);

    assert_tap_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_STEP && dqs_tap != TAP_MAX |=> dqs_tap == $past(dqs_tap) + TAP_W'(1));

    assert_sweep_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_STEP && dqs_tap == TAP_MAX |=> state == S_CHOOSE);

    assert_err_from_choose_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_err) |-> $past(state) == S_CHOOSE);

    assert_results_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done && !cal_start |=> cal_done && $stable(dqs_tap) && $stable(bit_taps) && $stable(cal_err));
endmodule

bind rl_deskew_cal rl_deskew_cal_chk #(.NBITS(NBITS), .TAP_W(TAP_W), .BTAP_W(BTAP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cal_start (cal_start),
    .cal_done  (cal_done),
    .cal_err   (cal_err),
    .dqs_tap   (dqs_tap),
    .bit_taps  (bit_taps),
    .state     (state_q)
);

// File: tb/sim_rl_deskew_cal.sv
module sim_rl_deskew_cal;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 8;
    localparam int TW = 5;
    localparam int BW = 4;
    localparam int NT = 1 << TW;

    typedef struct packed {
        logic [4:0] lo;
        logic [4:0] hi;
        logic [2:0] skew;
        logic [4:0] lo2;
        logic [4:0] hi2;
        logic [7:0] dead;
        logic [3:0] gbit;
        logic [4:0] gtap;
        logic [4:0] strobe;
        logic       err;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{5'd8,  5'd20, 3'd0, 5'd31, 5'd0,  8'h00, 4'd15, 5'd0,  5'd14, 1'b0}, // common window
        '{5'd4,  5'd12, 3'd1, 5'd0,  5'd0,  8'h00, 4'd15, 5'd0,  5'd11, 1'b0}, // skewed, island at 0
        '{5'd2,  5'd6,  3'd2, 5'd31, 5'd0,  8'h00, 4'd15, 5'd0,  5'd11, 1'b0}, // no overlap -> union
        '{5'd0,  5'd31, 3'd0, 5'd31, 5'd0,  8'h00, 4'd15, 5'd0,  5'd15, 1'b0}, // all pass
        '{5'd2,  5'd5,  3'd0, 5'd10, 5'd13, 8'h00, 4'd15, 5'd0,  5'd3,  1'b0}, // tie -> lower
        '{5'd1,  5'd2,  3'd0, 5'd20, 5'd29, 8'h00, 4'd15, 5'd0,  5'd24, 1'b0}, // later run longer
        '{5'd8,  5'd20, 3'd0, 5'd31, 5'd0,  8'h00, 4'd5,  5'd10, 5'd15, 1'b0}, // fall glitch bit5
        '{5'd8,  5'd20, 3'd0, 5'd31, 5'd0,  8'h08, 4'd15, 5'd0,  5'd14, 1'b1}, // bit3 dead
        '{5'd0,  5'd0,  3'd0, 5'd31, 5'd0,  8'hFF, 4'd15, 5'd0,  5'd0,  1'b1}  // all dead
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_start = 1'b0;
    logic cal_done, cal_err;
    logic [TW-1:0] dqs_tap;
    logic [NB*BW-1:0] bit_taps;
    logic cap_valid = 1'b0;
    logic [NB-1:0] cap_rise = '0, cap_fall = '0;
    logic [NB-1:0] exp_rise = 8'hA5, exp_fall = 8'h5A;

    int checks = 0;
    int errors = 0;
    vec_t cv;
    logic running = 1'b0;
    logic alt = 1'b0;
    int inc_cnt = 0;
    int prev_tap = 0;
    int zero_viol = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rl_deskew_cal u0 (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cal_done(cal_done),
        .cal_err(cal_err), .dqs_tap(dqs_tap), .bit_taps(bit_taps),
        .cap_valid(cap_valid), .cap_rise(cap_rise), .cap_fall(cap_fall),
        .exp_rise(exp_rise), .exp_fall(exp_fall)
    );

    function automatic logic pass_of(int b, int t, logic with_glitch);
        int lo_b, hi_b;
        if (cv.dead[b]) return 1'b0;
        if (with_glitch && b == int'(cv.gbit) && t == int'(cv.gtap)) return 1'b0;
        lo_b = int'(cv.lo) + b * int'(cv.skew);
        hi_b = int'(cv.hi) + b * int'(cv.skew);
        return (t >= lo_b && t <= hi_b) || (t >= int'(cv.lo2) && t <= int'(cv.hi2));
    endfunction

    task automatic check(string req, int act, int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // stimulus: captured data follows the current strobe tap (R3, R4)
    initial forever begin
        @(negedge clk);
        cap_valid = ~cap_valid;
        if (cap_valid) begin
            alt = ~alt;
            for (int b = 0; b < NB; b++) begin
                logic ok;
                ok = pass_of(b, int'(dqs_tap), 1'b0);
                cap_rise[b] = exp_rise[b] ^ ~ok;
                cap_fall[b] = exp_fall[b] ^ ~ok ^
                    (alt && b == int'(cv.gbit) && int'(dqs_tap) == int'(cv.gtap));
            end
        end else begin
            cap_rise = ~exp_rise;   // garbage on invalid cycles must be ignored
            cap_fall = ~exp_fall;
        end
    end

    // sweep monitor
    initial forever begin
        @(negedge clk);
        if (running) begin
            if (int'(dqs_tap) == prev_tap + 1) inc_cnt++;
            if (!cal_done && bit_taps != '0) zero_viol++;
        end
        prev_tap = int'(dqs_tap);
    end

    task automatic run_cal(int idx, logic poke);
        int n;
        cv = VECS[idx];
        exp_rise = 8'hA5 ^ 8'(idx * 17);
        exp_fall = ~exp_rise ^ 8'(idx);
        inc_cnt = 0;
        zero_viol = 0;
        @(negedge clk);
        cal_start = 1'b1;
        running = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        check("R2 err cleared on start", int'(cal_err), 0);
        check("R2 done cleared on start", int'(cal_done), 0);
        if (poke) begin
            repeat (60) @(negedge clk);
            cal_start = 1'b1;       // ignored while busy (R2)
            @(negedge clk);
            cal_start = 1'b0;
        end
        n = 0;
        while (!cal_done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        running = 1'b0;
        check("R11 done reached", int'(cal_done), 1);
    endtask

    task automatic check_results(int idx);
        int strobe, f, l, bl, rs, rl, c, d;
        strobe = int'(VECS[idx].strobe);
        check($sformatf("R7 R8 strobe vec%0d", idx), int'(dqs_tap), strobe);
        check($sformatf("R10 err vec%0d", idx), int'(cal_err), int'(VECS[idx].err));
        check($sformatf("R5 tap increments vec%0d", idx), inc_cnt, NT - 1);
        check($sformatf("R2 bit taps zero in sweep vec%0d", idx), zero_viol, 0);
        for (int b = 0; b < NB; b++) begin
            bl = 0; rl = 0; rs = 0; f = 0; l = 0;
            for (int t = 0; t < NT; t++) begin
                if (pass_of(b, t, 1'b1)) begin
                    if (rl == 0) rs = t;
                    rl++;
                    if (rl > bl) begin bl = rl; f = rs; l = t; end  // R6
                end else rl = 0;
            end
            if (bl == 0) d = 0;
            else begin
                c = (f + l) / 2;
                d = strobe - c;
                if (d < 0) d = 0;
                if (d > (1 << BW) - 1) d = (1 << BW) - 1;
            end
            check($sformatf("R9 R6 bit%0d tap vec%0d", b, idx), int'(bit_taps[b*BW +: BW]), d);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [TW-1:0] held_tap;
        logic [NB*BW-1:0] held_bits;
        cv = VECS[0];
        repeat (3) @(negedge clk);
        check("R1 done after reset", int'(cal_done), 0);
        check("R1 err after reset", int'(cal_err), 0);
        check("R1 strobe after reset", int'(dqs_tap), 0);
        check("R1 bit taps after reset", int'(bit_taps), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk (R3..R10)
        for (int i = 0; i < NV; i++) begin
            run_cal(i, i == 1);
            check_results(i);
        end

        // R10/R11: sticky error and frozen results after an all-dead run
        held_tap = dqs_tap;
        held_bits = bit_taps;
        repeat (20) @(negedge clk);
        check("R10 err sticky in done", int'(cal_err), 1);
        check("R11 done held", int'(cal_done), 1);
        check("R11 strobe held", int'(dqs_tap), int'(held_tap));
        check("R11 bit taps held", int'(bit_taps == held_bits), 1);

        // restart clears error and recalibrates (R2)
        run_cal(0, 1'b0);
        check_results(0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule